// File: doc/BRIEF.md
# JTAG Single-Bit Shift Sequencer

This block turns one command into one complete JTAG bit cycle on a byte-wide pin register. A command carries the value for TMS, the value for TDI and a flag that asks for TDO to be read back. The sequencer first presents TMS and TDI while TCK is low. If a read-back was requested, it spends one extra clock and samples TDO. It then raises TCK and finally lowers it again, keeping TMS and TDI unchanged. When the cycle is over it pulses `done` for one clock and leaves the captured TDO bit on its output.

Every TCK phase lasts a run-time number of system clocks. That number is raised to a floor derived from the system clock frequency, so that the generated TCK can never run faster than the configured maximum rate.

The pins are carried as byte images. The outgoing image has TDI, TMS and TCK at fixed bit positions. The incoming image carries TDO in its top bit. By default that bit is inverted on the way in, and the block inverts it back.

Top module: `jtag_bit_seq`

## Requirements
- R1: While `rst` is high and after it is released, until the first command is accepted, `port_out` is 8'h02 (TCK low, TMS high, TDI low), and `busy`, `done` and `tdo_bit` are 0.
- R2: In `port_out`, bit 6 is TDI, bit 1 is TMS and bit 0 is TCK. Bits 7, 5, 4, 3 and 2 are always 0.
- R3: A command is accepted on a rising clock edge where `cmd_valid` is 1 and `busy` is 0. `busy` is 1 from the next clock until the cycle completes. A `cmd_valid` offered while `busy` is 1 is ignored and changes neither the pins nor the result.
- R4: With phase length D, the pins follow a fixed order. First comes a setup phase of D clocks with TCK=0 and the new TDI and TMS. Then, with the optional sample clock between them, comes a phase of D clocks with TCK=1, then a phase of D clocks with TCK=0. TDI and TMS do not change while `busy` is 1.
- R5: When `cmd_capture` is 1, one sample clock follows the setup phase. TDO is taken on the same clock edge at which TCK goes high, so the captured value is the one present before TCK rises. The command then keeps `busy` high for 3*D+1 clocks.
- R6: TDO is read from bit 7 of `port_in`. With INVERT_TDO=1 (the default), `tdo_bit` is the inverse of that bit. With INVERT_TDO=0 it is the bit itself.
- R7: When `cmd_capture` is 0, no sample clock is spent, `busy` lasts 3*D clocks and `tdo_bit` reads 0.
- R8: D is the larger of `div_len` and MIN_DIV, where MIN_DIV = ceil(SYS_CLK_HZ / (2*TCK_MAX_HZ)) with a lower bound of 1. At the default 100 MHz and 18 MHz this gives MIN_DIV = 3. D is latched when the command is accepted, so later changes of `div_len` do not affect the running cycle.
- R9: `done` is 1 for exactly one clock, the first clock after `busy` falls. `tdo_bit` then holds its value until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_tms | input | 1 | TMS value for this bit |
| cmd_tdi | input | 1 | TDI value for this bit |
| cmd_capture | input | 1 | Request TDO read-back |
| div_len | input | DIV_W | Requested clocks per TCK phase |
| port_in | input | 8 | Incoming pin image, TDO at bit 7 |
| port_out | output | 8 | Outgoing pin image: TDI bit 6, TMS bit 1, TCK bit 0 |
| busy | output | 1 | Bit cycle in progress |
| done | output | 1 | One-clock completion strobe |
| tdo_bit | output | 1 | Captured TDO, valid from `done` |

## Verification
Two events share a single clock edge: the TDO sample and the rise of TCK. A fault could move the sample one clock later, after TCK is already high. To expose this, the bench flips the incoming TDO bit in the first clock in which it sees TCK high. It then requires the returned bit to match the value from before the flip. A second pair of events, the completion strobe and the acceptance of the next command, also meet in one cycle: the bench offers a new command in the very `done` cycle and checks that both results arrive in order through its scoreboard.

// File: rtl/jtag_bit_pkg.sv
package jtag_bit_pkg;

    localparam int IMG_W   = 8;
    localparam int TDI_POS = 6;
    localparam int TMS_POS = 1;
    localparam int TCK_POS = 0;
    localparam int TDO_POS = 7;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_SAMPLE,
        PH_HIGH,
        PH_LOW
    } phase_e;

    typedef struct packed {
        logic tms;
        logic tdi;
        logic capture;
    } bit_cmd_t;

    function automatic logic [IMG_W-1:0] build_image(logic tdi, logic tms, logic tck);
        logic [IMG_W-1:0] img;
        img          = '0;
        img[TDI_POS] = tdi;
        img[TMS_POS] = tms;
        img[TCK_POS] = tck;
        return img;
    endfunction

    function automatic int unsigned phase_floor(int unsigned sys_hz, int unsigned max_hz);
        int unsigned q;
        q = (sys_hz + 2 * max_hz - 1) / (2 * max_hz);
        return (q < 1) ? 1 : q;
    endfunction

endpackage

// File: rtl/jbs_phase_timer.sv
module jbs_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= len - W'(1);
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/jbs_sequencer.sv
module jbs_sequencer
    import jtag_bit_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cmd_valid,
    input  logic   cmd_capture,
    input  logic   timer_last,
    output phase_e state,
    output logic   accept,
    output logic   load,
    output logic   tck_rise,
    output logic   tck_fall,
    output logic   sample_now,
    output logic   finish
);
    phase_e next;
    logic   cap_q;

    always_comb begin
        next       = state;
        accept     = 1'b0;
        load       = 1'b0;
        tck_rise   = 1'b0;
        tck_fall   = 1'b0;
        sample_now = 1'b0;
        finish     = 1'b0;
        case (state)
            PH_IDLE: if (cmd_valid) begin
                accept = 1'b1;
                load   = 1'b1;
                next   = PH_SETUP;
            end
            PH_SETUP: if (timer_last) begin
                load = 1'b1;
                if (cap_q) begin
                    next = PH_SAMPLE;
                end else begin
                    next     = PH_HIGH;
                    tck_rise = 1'b1;
                end
            end
            PH_SAMPLE: begin
                sample_now = 1'b1;
                tck_rise   = 1'b1;
                load       = 1'b1;
                next       = PH_HIGH;
            end
            PH_HIGH: if (timer_last) begin
                tck_fall = 1'b1;
                load     = 1'b1;
                next     = PH_LOW;
            end
            PH_LOW: if (timer_last) begin
                finish = 1'b1;
                next   = PH_IDLE;
            end
            default: next = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PH_IDLE;
            cap_q <= 1'b0;
        end else begin
            state <= next;
            if (accept)
                cap_q <= cmd_capture;
        end
    end

    // R3
    accept_idle_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> (state == PH_IDLE));

    // R5
    sample_path_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PH_SAMPLE) |-> $past(state) == PH_SETUP && cap_q);
endmodule

// File: rtl/jbs_pin_image.sv
module jbs_pin_image
    import jtag_bit_pkg::*;
#(
    parameter bit INVERT_TDO = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  bit_cmd_t         cmd,
    input  logic             tck_rise,
    input  logic             tck_fall,
    input  logic             sample_now,
    input  logic             finish,
    input  logic [IMG_W-1:0] port_in,
    output logic [IMG_W-1:0] port_out,
    output logic             tdo_bit,
    output logic             done
);
    logic tdi_q, tms_q, tck_q, tdo_q, done_q;
    logic unused_port_bits;

    assign unused_port_bits = ^{port_in[TDO_POS-1:0], cmd.capture};

    always_ff @(posedge clk) begin
        if (rst) begin
            tdi_q  <= 1'b0;
            tms_q  <= 1'b1;
            tck_q  <= 1'b0;
            tdo_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept) begin
                tdi_q <= cmd.tdi;
                tms_q <= cmd.tms;
                tdo_q <= 1'b0;
            end
            if (tck_rise)
                tck_q <= 1'b1;
            else if (tck_fall)
                tck_q <= 1'b0;
            if (sample_now)
                tdo_q <= port_in[TDO_POS] ^ INVERT_TDO;
        end
    end

    assign port_out = build_image(tdi_q, tms_q, tck_q);
    assign tdo_bit  = tdo_q;
    assign done     = done_q;

    // R2
    image_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (port_out & 8'hBC) == 8'h00);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    tdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!accept && !sample_now) |=> $stable(tdo_q));
endmodule

// File: rtl/jtag_bit_seq.sv
module jtag_bit_seq
    import jtag_bit_pkg::*;
#(
    parameter int          DIV_W      = 8,
    parameter bit          INVERT_TDO = 1'b1,
    parameter int unsigned SYS_CLK_HZ = 100_000_000,
    parameter int unsigned TCK_MAX_HZ = 18_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_tms,
    input  logic             cmd_tdi,
    input  logic             cmd_capture,
    input  logic [DIV_W-1:0] div_len,
    input  logic [7:0]       port_in,
    output logic [7:0]       port_out,
    output logic             busy,
    output logic             done,
    output logic             tdo_bit
);
    localparam int unsigned MIN_DIV = phase_floor(SYS_CLK_HZ, TCK_MAX_HZ);
    localparam logic [DIV_W-1:0] MIN_DIV_V = DIV_W'(MIN_DIV);

    phase_e           state;
    logic             accept, load, tck_rise, tck_fall, sample_now, finish, last;
    logic [DIV_W-1:0] eff_now, eff_q, len;
    bit_cmd_t         cmd;

    assign cmd     = '{tms: cmd_tms, tdi: cmd_tdi, capture: cmd_capture};
    assign eff_now = (div_len < MIN_DIV_V) ? MIN_DIV_V : div_len;
    assign len     = accept ? eff_now : eff_q;
    assign busy    = (state != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst)
            eff_q <= MIN_DIV_V;
        else if (accept)
            eff_q <= eff_now;
    end

    jbs_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_capture(cmd_capture),
        .timer_last (last),
        .state      (state),
        .accept     (accept),
        .load       (load),
        .tck_rise   (tck_rise),
        .tck_fall   (tck_fall),
        .sample_now (sample_now),
        .finish     (finish)
    );

    jbs_phase_timer #(.W(DIV_W)) u_timer (
        .clk (clk),
        .rst (rst),
        .load(load),
        .len (len),
        .last(last)
    );

    jbs_pin_image #(.INVERT_TDO(INVERT_TDO)) u_img (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .cmd       (cmd),
        .tck_rise  (tck_rise),
        .tck_fall  (tck_fall),
        .sample_now(sample_now),
        .finish    (finish),
        .port_in   (port_in),
        .port_out  (port_out),
        .tdo_bit   (tdo_bit),
        .done      (done)
    );

    // R4
    pins_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(port_out[TDI_POS]) && $stable(port_out[TMS_POS])));

    // R5
    rise_after_sample_chk: assert property (@(posedge clk) disable iff (rst)
        sample_now |=> port_out[TCK_POS]);

    // R4
    tck_low_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !port_out[TCK_POS]);
endmodule

// File: tb/tb_jtag_bit_seq.sv
module tb_jtag_bit_seq;
    localparam int CLK_PERIOD = 10;
    localparam int MIN_D = 3;

    typedef struct {
        int d;
        bit cap;
        bit tms;
        bit tdi;
        bit tdo;
        bit tdo_ni;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0, cmd_tms = 1'b0, cmd_tdi = 1'b0, cmd_capture = 1'b0;
    logic [7:0] div_len = 8'd1;
    logic [7:0] port_in = 8'h00;
    logic [7:0] port_out, port_out_ni;
    logic       busy, done, tdo_bit, busy_ni, done_ni, tdo_ni;

    int   checks = 0, errors = 0;
    exp_t q[$];
    int   busy_cnt = 0, hi_cnt = 0;
    bit   hi_seen = 0;
    bit   flip_on_high = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jtag_bit_seq dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_tms(cmd_tms), .cmd_tdi(cmd_tdi),
        .cmd_capture(cmd_capture), .div_len(div_len), .port_in(port_in),
        .port_out(port_out), .busy(busy), .done(done), .tdo_bit(tdo_bit));

    jtag_bit_seq #(.INVERT_TDO(1'b0)) dut_ni (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_tms(cmd_tms), .cmd_tdi(cmd_tdi),
        .cmd_capture(cmd_capture), .div_len(div_len), .port_in(port_in),
        .port_out(port_out_ni), .busy(busy_ni), .done(done_ni), .tdo_bit(tdo_ni));

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // driver: wait for idle, offer one command, push the expectation
    task automatic send(bit tms, bit tdi, bit cap, int div, bit pin, bit noise);
        exp_t e;
        while (busy) @(negedge clk);
        port_in = {pin, 7'h00};
        div_len = 8'(div);
        cmd_tms = tms; cmd_tdi = tdi; cmd_capture = cap; cmd_valid = 1'b1;
        e.d = (div < MIN_D) ? MIN_D : div;
        e.cap = cap; e.tms = tms; e.tdi = tdi;
        e.tdo = cap ? ~pin : 1'b0;
        e.tdo_ni = cap ? pin : 1'b0;
        q.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (noise) begin
            // R3: commands during busy must be ignored; R8: div change must not matter
            div_len = 8'd9;
            cmd_tms = ~tms; cmd_tdi = ~tdi; cmd_capture = ~cap;
            cmd_valid = 1'b1;
            repeat (5) @(negedge clk);
            cmd_valid = 1'b0;
        end
    endtask

    // monitor: counts phases and scores results on done
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) begin
                busy_cnt++;
                if (port_out[0]) begin
                    hi_cnt++;
                    if (!hi_seen) begin
                        hi_seen = 1;
                        if (q.size() > 0) begin
                            check(busy_cnt == q[0].d + int'(q[0].cap) + 1, "R4/R5 setup length",
                                  busy_cnt, q[0].d + int'(q[0].cap) + 1);
                            check(port_out[1] == q[0].tms, "R4 TMS at rise", port_out[1], q[0].tms);
                            check(port_out[6] == q[0].tdi, "R4 TDI at rise", port_out[6], q[0].tdi);
                        end
                        if (flip_on_high) port_in[7] = ~port_in[7];
                    end
                end
            end
            if (done) begin
                if (q.size() == 0) begin
                    check(0, "R3 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(busy_cnt == 3 * e.d + int'(e.cap), "R5/R7/R8 busy length",
                          busy_cnt, 3 * e.d + int'(e.cap));
                    check(hi_cnt == e.d, "R4/R8 TCK high length", hi_cnt, e.d);
                    check(tdo_bit == e.tdo, "R6/R7 tdo_bit", tdo_bit, e.tdo);
                    check(tdo_ni == e.tdo_ni, "R6 non-inverting tdo", tdo_ni, e.tdo_ni);
                    check(port_out == {1'b0, e.tdi, 4'b0, e.tms, 1'b0}, "R2 image after cycle",
                          port_out, {1'b0, e.tdi, 4'b0, e.tms, 1'b0});
                end
                busy_cnt = 0; hi_cnt = 0; hi_seen = 0;
            end
        end
    end

    initial begin : main
        fork
            begin
                repeat (4) @(negedge clk);
                // R1 during reset
                check(port_out == 8'h02, "R1 port_out in reset", port_out, 8'h02);
                rst = 1'b0;
                @(negedge clk); @(negedge clk);
                check(port_out == 8'h02, "R1 port_out after reset", port_out, 8'h02);
                check(!busy && !done && !tdo_bit, "R1 flags idle", {busy, done, tdo_bit}, 0);

                send(1, 0, 1, 1, 0, 0);   // R8: div 1 raised to 3, R6 inverted pin
                send(0, 1, 0, 5, 1, 0);   // R7: no capture, D=5
                send(1, 1, 1, 0, 1, 0);   // R8: div 0
                send(0, 0, 1, 4, 0, 1);   // R3/R8: noise while busy
                flip_on_high = 1;
                send(1, 0, 1, 3, 1, 0);   // R5: pin flips once TCK is high
                send(0, 1, 1, 6, 0, 0);   // R5 again
                flip_on_high = 0;
                // back-to-back: next command offered in the done cycle
                send(1, 1, 1, 3, 1, 0);
                while (!done) @(negedge clk);
                send(0, 0, 0, 3, 0, 0);
                while (busy || q.size() > 0) @(negedge clk);
                repeat (3) @(negedge clk);
                // R9: tdo_bit holds while idle, done was a single pulse
                check(tdo_bit == 1'b0 && !done, "R9 hold after done", {tdo_bit, done}, 0);
                check(q.size() == 0, "R3 no lost or extra results", q.size(), 0);
            end
            begin
                repeat (20000) @(posedge clk);
                check(0, "watchdog", 0, 1);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule